// File: doc/BRIEF.md
# Indexed display register port

This block is the software-visible register file of a simple display controller. Software reaches every register through two ports: a write to the index port chooses a register number, and every later access to the value port acts on that register until the index is changed. The register set holds the version ID, the enable and configuration-done state, the pending width and height, a guest identifier, the cursor ID, position and visibility, and a bank of general-purpose scratch words.

Some value-port reads are computed rather than stored. These are the maximum mode size, the bits per pixel, the bytes per line of the pending width, the command ring placement and size, and a fixed capability mask. The framebuffer size is latched from the pending geometry whenever enable is written. A one-cycle `ring_start_o` pulse tells the command ring reader to begin work. It fires after a write to the sync register, and after a write of 1 to configuration done.

Top module: `disp_regport`

## Requirements
- R1: Port select 0 is the index port and port select 1 is the value port. The index holds 12 bits and reads back on the index port. After reset the index is 0, enable is 0, configuration done is 0 and the cursor is off.
- R2: The ID register is number 0 and resets to 0x90000002. A write is stored only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R3: Register 4 reads 2360 and register 5 reads 1770. Register 19 reads 0x10000. Register 18 reads VRAM base plus VRAM size minus 0x10000. Register 15 reads VRAM size minus 0x10000.
- R4: Registers 7 and 28 read (DEPTH+7) rounded down to a multiple of 8. Register 12 reads ((DEPTH+7)>>3) times the pending width, where the width is register 2 and the height is register 3.
- R5: Register 6 reads DEPTH. A write to register 6 changes nothing, whether or not the value equals DEPTH.
- R6: Configuration done is register 20 and enable is register 1. A nonzero write to register 20 sets configuration done and a zero write clears it. A zero write to enable clears configuration done. A nonzero write to enable leaves it as it was.
- R7: Register 16 reads the framebuffer size. It is latched as bytes per pixel times pending width times pending height on each enable write. A width or height change does not alter it until the next enable write.
- R8: Cursor-on is register 27, bit 0. Writing 1 sets it and writing 0 clears it. Writing 2 or 3 leaves it unchanged.
- R9: Scratch registers sit at indices 1792 to 1792+SCR_N-1 and are read and written normally. An index from 1792+SCR_N up reads as zero and ignores writes.
- R10: `ring_start_o` is high for exactly the one cycle after a write to register 21, or after a write of 1 to register 20. A write of another value to register 20 gives no pulse.
- R11: Port select 2 or 3 reads zero, and writes to it change no register.
- R12: Register 17 reads the CAPS parameter. Cursor ID, X, Y and guest ID (24, 25, 26, 23) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the selected port |
| port_sel_i | input | 2 | 0 index, 1 value, 2/3 auxiliary |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected port (combinational) |
| ring_start_o | output | 1 | One-cycle command ring start pulse |

## Verification
Read data is combinational from the stored index and registers, so a read is due in the same cycle the port select is applied. The bench drives inputs at the falling edge and samples just after. A write takes effect at the rising edge that samples it, so every readback follows the write by at least one edge. The start pulse is due in the cycle after the write edge. The bench checks it high one time unit after that edge and low one edge later.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;
  localparam int IDX_W = 12;
  localparam int DW    = 32;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t REG_ID       = 12'd0;
  localparam idx_t REG_ENABLE   = 12'd1;
  localparam idx_t REG_WIDTH    = 12'd2;
  localparam idx_t REG_HEIGHT   = 12'd3;
  localparam idx_t REG_MAX_W    = 12'd4;
  localparam idx_t REG_MAX_H    = 12'd5;
  localparam idx_t REG_DEPTH    = 12'd6;
  localparam idx_t REG_BPP      = 12'd7;
  localparam idx_t REG_BPL      = 12'd12;
  localparam idx_t REG_VRAM_SZ  = 12'd15;
  localparam idx_t REG_FB_SZ    = 12'd16;
  localparam idx_t REG_CAPS     = 12'd17;
  localparam idx_t REG_RING_ST  = 12'd18;
  localparam idx_t REG_RING_SZ  = 12'd19;
  localparam idx_t REG_CFG      = 12'd20;
  localparam idx_t REG_SYNC     = 12'd21;
  localparam idx_t REG_BUSY     = 12'd22;
  localparam idx_t REG_GUEST    = 12'd23;
  localparam idx_t REG_CUR_ID   = 12'd24;
  localparam idx_t REG_CUR_X    = 12'd25;
  localparam idx_t REG_CUR_Y    = 12'd26;
  localparam idx_t REG_CUR_ON   = 12'd27;
  localparam idx_t REG_HOST_BPP = 12'd28;
  localparam idx_t REG_SCR_SZ   = 12'd29;
  localparam int   SCR_BASE     = 1792;

  localparam logic [DW-1:0] ID_MAGIC = 32'h9000_0000;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_VALUE = 2'd1,
    PORT_AUX0  = 2'd2,
    PORT_AUX1  = 2'd3
  } port_e;

  function automatic logic id_legal(logic [DW-1:0] v);
    return (v == ID_MAGIC) || (v == (ID_MAGIC | 32'd1)) || (v == (ID_MAGIC | 32'd2));
  endfunction
endpackage

// File: rtl/disp_scratch_bank.sv
module disp_scratch_bank
  import disp_regport_pkg::*;
#(
  parameter int N    = 8,
  parameter int BASE = SCR_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  idx_t          idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word_q [N];
  logic [N-1:0]  hit;

  for (genvar i = 0; i < N; i++) begin : g_word
    assign hit[i] = (idx_i == idx_t'(BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             word_q[i] <= '0;
      else if (we_i && hit[i]) word_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) rdata_o = word_q[i];
  end

  a_r9_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit));
endmodule

// File: rtl/disp_geom.sv
module disp_geom
  import disp_regport_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  output logic [DW-1:0] bpl_o,
  output logic [DW-1:0] fb_size_o
);
  localparam int BYPP = (DEPTH + 7) >> 3;
  logic [DW-1:0] line_bytes;
  assign line_bytes = DW'(BYPP) * width_i;
  assign bpl_o      = line_bytes;
  assign fb_size_o  = line_bytes * height_i;
endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import disp_regport_pkg::*;
#(
  parameter int          DEPTH     = 24,
  parameter int          SCR_N     = 8,
  parameter int          MAX_W     = 2360,
  parameter int          MAX_H     = 1770,
  parameter logic [31:0] VRAM_BASE = 32'hE000_0000,
  parameter logic [31:0] VRAM_SIZE = 32'h0100_0000,
  parameter logic [31:0] RING_SIZE = 32'h0001_0000,
  parameter logic [31:0] CAPS      = 32'h0000_0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  port_sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ring_start_o
);
  localparam int BPP = ((DEPTH + 7) >> 3) << 3;

  idx_t          idx_q;
  logic [DW-1:0] id_q, width_q, height_q, fb_q, guest_q, cur_id_q, cur_x_q, cur_y_q;
  logic          enable_q, cfg_q, cur_on_q, start_q;
  logic [DW-1:0] bpl, fb_calc, scr_rdata;
  logic          idx_wr, val_wr, start_d;

  assign idx_wr = wr_en_i && (port_sel_i == PORT_INDEX);
  assign val_wr = wr_en_i && (port_sel_i == PORT_VALUE);

  disp_geom #(.DEPTH(DEPTH)) u_geom (
    .width_i  (width_q),
    .height_i (height_q),
    .bpl_o    (bpl),
    .fb_size_o(fb_calc)
  );

  disp_scratch_bank #(.N(SCR_N), .BASE(SCR_BASE)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (val_wr),
    .idx_i  (idx_q),
    .wdata_i(wdata_i),
    .rdata_o(scr_rdata)
  );

  assign start_d = val_wr && ((idx_q == REG_SYNC) || ((idx_q == REG_CFG) && (wdata_i == 32'd1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      id_q     <= ID_MAGIC | 32'd2;
      enable_q <= 1'b0;
      cfg_q    <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      fb_q     <= '0;
      guest_q  <= '0;
      cur_id_q <= '0;
      cur_x_q  <= '0;
      cur_y_q  <= '0;
      cur_on_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      if (idx_wr) idx_q <= wdata_i[IDX_W-1:0];
      if (val_wr) begin
        case (idx_q)
          REG_ID:     if (id_legal(wdata_i)) id_q <= wdata_i;
          REG_ENABLE: begin
            enable_q <= |wdata_i;
            cfg_q    <= cfg_q & (|wdata_i);
            fb_q     <= fb_calc;
          end
          REG_WIDTH:  width_q  <= wdata_i;
          REG_HEIGHT: height_q <= wdata_i;
          REG_CFG:    cfg_q    <= |wdata_i;
          REG_GUEST:  guest_q  <= wdata_i;
          REG_CUR_ID: cur_id_q <= wdata_i;
          REG_CUR_X:  cur_x_q  <= wdata_i;
          REG_CUR_Y:  cur_y_q  <= wdata_i;
          REG_CUR_ON: begin
            // 1 shows, 0 hides, other codes keep the flag
            if (wdata_i == 32'd1)      cur_on_q <= 1'b1;
            else if (wdata_i == 32'd0) cur_on_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign ring_start_o = start_q;

  logic [DW-1:0] val_rd;
  always_comb begin
    case (idx_q)
      REG_ID:       val_rd = id_q;
      REG_ENABLE:   val_rd = {31'd0, enable_q};
      REG_WIDTH:    val_rd = width_q;
      REG_HEIGHT:   val_rd = height_q;
      REG_MAX_W:    val_rd = DW'(MAX_W);
      REG_MAX_H:    val_rd = DW'(MAX_H);
      REG_DEPTH:    val_rd = DW'(DEPTH);
      REG_BPP:      val_rd = DW'(BPP);
      REG_BPL:      val_rd = bpl;
      REG_VRAM_SZ:  val_rd = VRAM_SIZE - RING_SIZE;
      REG_FB_SZ:    val_rd = fb_q;
      REG_CAPS:     val_rd = CAPS;
      REG_RING_ST:  val_rd = VRAM_BASE + VRAM_SIZE - RING_SIZE;
      REG_RING_SZ:  val_rd = RING_SIZE;
      REG_CFG:      val_rd = {31'd0, cfg_q};
      REG_BUSY:     val_rd = '0;
      REG_GUEST:    val_rd = guest_q;
      REG_CUR_ID:   val_rd = cur_id_q;
      REG_CUR_X:    val_rd = cur_x_q;
      REG_CUR_Y:    val_rd = cur_y_q;
      REG_CUR_ON:   val_rd = {31'd0, cur_on_q};
      REG_HOST_BPP: val_rd = DW'(BPP);
      REG_SCR_SZ:   val_rd = DW'(SCR_N);
      default:      val_rd = scr_rdata;
    endcase
  end

  always_comb begin
    case (port_sel_i)
      PORT_INDEX: rdata_o = {{(DW-IDX_W){1'b0}}, idx_q};
      PORT_VALUE: rdata_o = val_rd;
      default:    rdata_o = '0;
    endcase
  end

  a_r2_id_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_legal(id_q));
  a_r6_disable_clears_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_wr && idx_q == REG_ENABLE && wdata_i == '0) |=> !cfg_q);
  a_r8_cursor_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_wr && idx_q == REG_CUR_ON && wdata_i > 32'd1) |=> $stable(cur_on_q));
  a_r10_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_start_o |-> $past(val_wr && (idx_q == REG_SYNC || idx_q == REG_CFG)));
  a_r11_aux_no_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && port_sel_i[1]) |=> $stable(idx_q));
  a_r7_fb_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(val_wr && idx_q == REG_ENABLE) |=> $stable(fb_q));
endmodule

// File: tb/disp_regport_test.sv
`timescale 1ns/1ps
module disp_regport_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  port_sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ring_start;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  disp_regport uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .port_sel_i(port_sel),
    .wdata_i(wdata), .rdata_o(rdata), .ring_start_o(ring_start)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] p, logic [31:0] d);
    @(negedge clk);
    port_sel = p; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wreg(int r, logic [31:0] d);
    wr(2'd0, r);
    wr(2'd1, d);
  endtask

  task automatic rreg(int r, output logic [31:0] d);
    wr(2'd0, r);
    @(negedge clk);
    port_sel = 2'd1; #1;
    d = rdata;
  endtask

  task automatic expect_reg(string req, int r, logic [31:0] exp);
    logic [31:0] d;
    rreg(r, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    @(negedge clk); port_sel = 2'd0; #1;
    chk("R1 index reset", rdata, 0);
    expect_reg("R1 enable reset", 1, 0);
    expect_reg("R1 cfg reset", 20, 0);
    expect_reg("R1 cursor reset", 27, 0);
    wr(2'd0, 12'd29);
    @(negedge clk); port_sel = 2'd0; #1;
    chk("R1 index readback", rdata, 29);
  endtask

  task automatic t_id();
    expect_reg("R2 id reset", 0, 32'h9000_0002);
    wreg(0, 32'h9000_0000);
    expect_reg("R2 id legal v0", 0, 32'h9000_0000);
    wreg(0, 32'h9000_0003);
    expect_reg("R2 id illegal v3", 0, 32'h9000_0000);
    wreg(0, 32'h1234_5678);
    expect_reg("R2 id illegal", 0, 32'h9000_0000);
    wreg(0, 32'h9000_0001);
    expect_reg("R2 id legal v1", 0, 32'h9000_0001);
  endtask

  task automatic t_consts();
    expect_reg("R3 max width", 4, 2360);
    expect_reg("R3 max height", 5, 1770);
    expect_reg("R3 ring size", 19, 32'h0001_0000);
    expect_reg("R3 ring start", 18, 32'hE0FF_0000);
    expect_reg("R3 vram size", 15, 32'h00FF_0000);
  endtask

  task automatic t_depth();
    expect_reg("R4 bpp", 7, 24);
    expect_reg("R4 host bpp", 28, 24);
    wreg(2, 640);
    expect_reg("R4 bytes per line", 12, 1920);
    wreg(2, 1);
    expect_reg("R4 bytes per line w1", 12, 3);
    wreg(6, 16);
    expect_reg("R5 depth unchanged", 6, 24);
    expect_reg("R5 bpp unchanged", 7, 24);
  endtask

  task automatic t_enable_cfg();
    wreg(20, 5);
    expect_reg("R6 cfg set", 20, 1);
    wreg(1, 7);
    expect_reg("R6 enable nonzero keeps cfg", 20, 1);
    expect_reg("R6 enable reads 1", 1, 1);
    wreg(1, 0);
    expect_reg("R6 enable zero clears cfg", 20, 0);
  endtask

  task automatic t_fbsize();
    wreg(2, 640);
    wreg(3, 480);
    wreg(1, 1);
    expect_reg("R7 fb size", 16, 921600);
    wreg(2, 800);
    expect_reg("R7 fb held", 16, 921600);
    wreg(1, 1);
    expect_reg("R7 fb relatched", 16, 1152000);
  endtask

  task automatic t_cursor();
    wreg(27, 1);
    expect_reg("R8 cursor show", 27, 1);
    wreg(27, 2);
    expect_reg("R8 cursor code2 hold", 27, 1);
    wreg(27, 0);
    expect_reg("R8 cursor hide", 27, 0);
    wreg(27, 3);
    expect_reg("R8 cursor code3 hold", 27, 0);
    wreg(25, 123); wreg(26, 456); wreg(24, 9); wreg(23, 32'h5001);
    expect_reg("R12 cursor x", 25, 123);
    expect_reg("R12 cursor y", 26, 456);
    expect_reg("R12 cursor id", 24, 9);
    expect_reg("R12 guest id", 23, 32'h5001);
    expect_reg("R12 caps", 17, 3);
  endtask

  task automatic t_scratch();
    wreg(1792, 32'hA5A5_0001);
    wreg(1799, 32'h5A5A_0007);
    expect_reg("R9 scratch first", 1792, 32'hA5A5_0001);
    expect_reg("R9 scratch last", 1799, 32'h5A5A_0007);
    wreg(1800, 32'hDEAD_BEEF);
    expect_reg("R9 scratch beyond", 1800, 0);
    expect_reg("R9 scratch size", 29, 8);
    expect_reg("R9 scratch neighbour intact", 1799, 32'h5A5A_0007);
  endtask

  task automatic t_pulse();
    chk("R10 idle low", {31'd0, ring_start}, 0);
    wr(2'd0, 21);
    wr(2'd1, 0);
    chk("R10 sync pulse", {31'd0, ring_start}, 1);
    @(posedge clk); #1;
    chk("R10 sync pulse ends", {31'd0, ring_start}, 0);
    wr(2'd0, 20);
    wr(2'd1, 1);
    chk("R10 cfg pulse", {31'd0, ring_start}, 1);
    @(posedge clk); #1;
    chk("R10 cfg pulse ends", {31'd0, ring_start}, 0);
    wr(2'd1, 2);
    chk("R10 cfg 2 no pulse", {31'd0, ring_start}, 0);
  endtask

  task automatic t_aux();
    wr(2'd0, 25);
    wr(2'd2, 27);
    wr(2'd3, 99);
    @(negedge clk); port_sel = 2'd0; #1;
    chk("R11 index untouched", rdata, 25);
    expect_reg("R11 cursor x untouched", 25, 123);
    @(negedge clk); port_sel = 2'd2; #1;
    chk("R11 aux reads zero", rdata, 0);
    port_sel = 2'd3; #1;
    chk("R11 aux1 reads zero", rdata, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_id();
    t_consts();
    t_depth();
    t_enable_cfg();
    t_fbsize();
    t_cursor();
    t_scratch();
    t_pulse();
    t_aux();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule